// File: doc/BRIEF.md
# Per-Terminal Bus Changeover Monitor

This block supervises a dual-redundant command/response bus on behalf of the bus controller. After every completed transaction it is told which remote terminal was addressed and whether the exchange succeeded. For each terminal it tracks which of the two buses (A or B) the terminal should be reached on and how far that terminal has escalated through the fault stages. It also raises a controller changeover request when the controller itself looks at fault.

Escalation is strictly count-based and never retries a transaction, so bus timing stays deterministic. A run of consecutive failures moves a terminal to its other bus. A further run of failures on the new bus marks the terminal as down. When both of two designated terminals are down, the fault is blamed on the controller and the block requests safe mode. Software can revive a down terminal with a per-address clear. It can also read a saturating per-terminal error count for diagnostics.

Top module: `bus_chg_monitor`

## Requirements
- R1: After reset, no terminal is down, `safe_mode_req` is 0 and every error count reads 0. Each terminal's `bus_sel` bit (0 = bus A, 1 = bus B) equals its bit of parameter INIT_BUS_B, which defaults to 32'h0000_00F0 so terminals 4 to 7 start on bus B.
- R2: A passing result (`res_valid`=1, `res_pass`=1) to a terminal that is not down zeroes that terminal's consecutive-failure run. Two failures, a pass and two more failures therefore cause no bus change.
- R3: The SWAP_LIMIT-th consecutive failing result (default 3) to a terminal on its initial bus inverts that terminal's `bus_sel` bit. The change is visible in the cycle after the result is sampled.
- R4: Once a terminal has been moved, FAIL_LIMIT further consecutive failing results (default 3) set its `term_failed` bit in the cycle after the last one. Its `bus_sel` bit stays on the alternate bus. Passes in between restart the run but do not move the terminal back.
- R5: While a terminal is down, results addressed to it change neither its `bus_sel` bit nor its error count.
- R6: A clear (`clr_valid`=1 with `clr_addr`) restores that terminal to its initial bus, with no down flag and an empty failure run, in the next cycle. Its error count is kept.
- R7: Every failing result to a terminal that is not down adds one to that terminal's error count, which saturates at 255. `diag_err` shows the count of the terminal selected by `diag_addr` combinationally.
- R8: `safe_mode_req` rises one cycle after both designated terminals (WATCH_A=1 and WATCH_B=2) are down at the same time. It then stays high until reset, even if those terminals are cleared. One designated terminal down alone never raises it.
- R9: A result or clear changes only the state of the terminal it addresses.
- R10: If a clear and a result address the same terminal in the same cycle, the clear wins and the result is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A transaction result is present this cycle |
| res_addr | input | 5 | Terminal address of the result |
| res_pass | input | 1 | 1 = transaction succeeded, 0 = failed |
| clr_valid | input | 1 | Software clear request this cycle |
| clr_addr | input | 5 | Terminal address to clear |
| diag_addr | input | 5 | Terminal whose error count is shown on diag_err |
| bus_sel | output | 32 | Per-terminal bus choice, 0 = A, 1 = B |
| term_failed | output | 32 | Per-terminal down flag |
| safe_mode_req | output | 1 | Controller changeover (safe mode) request, sticky |
| diag_err | output | 8 | Saturating error count of terminal diag_addr |

## Verification
On every cycle the assertions enforce the rules about locality and stickiness. A bus bit or down flag may change only at an addressed terminal. A down flag can appear only after a failing result and can vanish only through a clear. A down terminal's bus bit is frozen. The safe-mode request never drops, and it rises only after both designated terminals were down. The counting itself cannot be shown by those cycle-local properties, so the bench's scenarios cover it. Those scenarios include the exact cycle of the swap and of the down declaration, the reset of the run by a pass, the clear winning a same-cycle conflict, and error-count saturation after long pass/fail patterns. The bench's behavioural model checks all of these on every clock.

// File: rtl/bus_chg_pkg.sv
package bus_chg_pkg;

    localparam int CONSEC_W = 4;
    localparam int ERR_W    = 8;

    typedef enum logic [1:0] {
        STG_PRIMARY   = 2'd0,
        STG_ALTERNATE = 2'd1,
        STG_DOWN      = 2'd2
    } stage_e;

    typedef struct packed {
        stage_e                stage;
        logic [CONSEC_W-1:0]   consec;
        logic                  bus_b;
        logic [ERR_W-1:0]      errs;
    } term_state_t;

    function automatic term_state_t fresh_state(logic bus_b, logic [ERR_W-1:0] keep_errs);
        term_state_t s;
        s.stage  = STG_PRIMARY;
        s.consec = '0;
        s.bus_b  = bus_b;
        s.errs   = keep_errs;
        return s;
    endfunction

    function automatic term_state_t apply_result(term_state_t cur, logic pass,
                                                 logic [CONSEC_W-1:0] swap_lim,
                                                 logic [CONSEC_W-1:0] down_lim);
        term_state_t nxt;
        logic [CONSEC_W-1:0] run;
        logic [CONSEC_W-1:0] lim;
        nxt = cur;
        run = cur.consec + 1'b1;
        lim = (cur.stage == STG_PRIMARY) ? swap_lim : down_lim;
        if (cur.stage != STG_DOWN) begin
            if (pass) begin
                nxt.consec = '0;
            end else begin
                if (cur.errs != '1) begin
                    nxt.errs = cur.errs + 1'b1;
                end
                if (run >= lim) begin
                    nxt.consec = '0;
                    if (cur.stage == STG_PRIMARY) begin
                        nxt.stage = STG_ALTERNATE;
                        nxt.bus_b = ~cur.bus_b;
                    end else begin
                        nxt.stage = STG_DOWN;
                    end
                end else begin
                    nxt.consec = run;
                end
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bus_chg_decode.sv
module bus_chg_decode #(
    parameter int NUM_TERM = 32,
    parameter int AW       = 5
) (
    input  logic                valid,
    input  logic [AW-1:0]       addr,
    output logic [NUM_TERM-1:0] hit
);
    for (genvar i = 0; i < NUM_TERM; i++) begin : g_dec
        assign hit[i] = valid && (addr == AW'(i));
    end
endmodule

// File: rtl/bus_chg_entry.sv
module bus_chg_entry
    import bus_chg_pkg::*;
#(
    parameter int   SWAP_LIMIT = 3,
    parameter int   FAIL_LIMIT = 3,
    parameter logic INIT_B     = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_hit,
    input  logic             res_pass,
    input  logic             clr_hit,
    output logic             bus_b,
    output logic             down,
    output logic [ERR_W-1:0] err_cnt
);
    localparam logic [CONSEC_W-1:0] SWAP_L = CONSEC_W'(SWAP_LIMIT);
    localparam logic [CONSEC_W-1:0] DOWN_L = CONSEC_W'(FAIL_LIMIT);

    term_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= fresh_state(INIT_B, '0);
        end else if (clr_hit) begin
            st <= fresh_state(INIT_B, st.errs);
        end else if (res_hit) begin
            st <= apply_result(st, res_pass, SWAP_L, DOWN_L);
        end
    end

    assign bus_b   = st.bus_b;
    assign down    = (st.stage == STG_DOWN);
    assign err_cnt = st.errs;
endmodule

// File: rtl/bus_chg_safe.sv
module bus_chg_safe #(
    parameter int NUM_TERM = 32,
    parameter int WATCH_A  = 1,
    parameter int WATCH_B  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TERM-1:0] down_vec,
    output logic                safe_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            safe_req <= 1'b0;
        end else if (down_vec[WATCH_A] && down_vec[WATCH_B]) begin
            safe_req <= 1'b1;
        end
    end
endmodule

// File: rtl/bus_chg_monitor.sv
module bus_chg_monitor
    import bus_chg_pkg::*;
#(
    parameter int                NUM_TERM   = 32,
    parameter int                SWAP_LIMIT = 3,
    parameter int                FAIL_LIMIT = 3,
    parameter int                WATCH_A    = 1,
    parameter int                WATCH_B    = 2,
    parameter logic [NUM_TERM-1:0] INIT_BUS_B = 32'h0000_00F0,
    localparam int               AW         = $clog2(NUM_TERM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                res_valid,
    input  logic [AW-1:0]       res_addr,
    input  logic                res_pass,
    input  logic                clr_valid,
    input  logic [AW-1:0]       clr_addr,
    input  logic [AW-1:0]       diag_addr,
    output logic [NUM_TERM-1:0] bus_sel,
    output logic [NUM_TERM-1:0] term_failed,
    output logic                safe_mode_req,
    output logic [ERR_W-1:0]    diag_err
);
    logic [NUM_TERM-1:0] res_hit;
    logic [NUM_TERM-1:0] clr_hit;
    logic [ERR_W-1:0]    err_arr [NUM_TERM];

    bus_chg_decode #(.NUM_TERM(NUM_TERM), .AW(AW)) u_res_dec (
        .valid(res_valid), .addr(res_addr), .hit(res_hit)
    );

    bus_chg_decode #(.NUM_TERM(NUM_TERM), .AW(AW)) u_clr_dec (
        .valid(clr_valid), .addr(clr_addr), .hit(clr_hit)
    );

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        bus_chg_entry #(
            .SWAP_LIMIT(SWAP_LIMIT),
            .FAIL_LIMIT(FAIL_LIMIT),
            .INIT_B    (INIT_BUS_B[t])
        ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .res_hit (res_hit[t]),
            .res_pass(res_pass),
            .clr_hit (clr_hit[t]),
            .bus_b   (bus_sel[t]),
            .down    (term_failed[t]),
            .err_cnt (err_arr[t])
        );
    end

    bus_chg_safe #(.NUM_TERM(NUM_TERM), .WATCH_A(WATCH_A), .WATCH_B(WATCH_B)) u_safe (
        .clk     (clk),
        .rst     (rst),
        .down_vec(term_failed),
        .safe_req(safe_mode_req)
    );

    assign diag_err = err_arr[diag_addr];
endmodule

// File: rtl/bus_chg_monitor_chk.sv
module bus_chg_monitor_chk #(
    parameter int NUM_TERM = 32,
    parameter int WATCH_A  = 1,
    parameter int WATCH_B  = 2,
    parameter int AW       = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                res_valid,
    input logic [AW-1:0]       res_addr,
    input logic                res_pass,
    input logic                clr_valid,
    input logic [AW-1:0]       clr_addr,
    input logic [NUM_TERM-1:0] bus_sel,
    input logic [NUM_TERM-1:0] term_failed,
    input logic                safe_mode_req
);
    logic [NUM_TERM-1:0] res_mask;
    logic [NUM_TERM-1:0] fail_mask;
    logic [NUM_TERM-1:0] clr_mask;

    always_comb begin
        for (int i = 0; i < NUM_TERM; i++) begin
            res_mask[i]  = res_valid && (res_addr == AW'(i));
            fail_mask[i] = res_mask[i] && !res_pass;
            clr_mask[i]  = clr_valid && (clr_addr == AW'(i));
        end
    end

    AST_BUS_LOCAL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((bus_sel ^ $past(bus_sel)) & ~($past(res_mask) | $past(clr_mask))) == '0)); // R9

    AST_DOWN_NEEDS_FAIL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((term_failed & ~$past(term_failed)) & ~$past(fail_mask)) == '0)); // R4

    AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(term_failed) & ~term_failed) & ~$past(clr_mask)) == '0)); // R6

    AST_DOWN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((bus_sel ^ $past(bus_sel)) & $past(term_failed) & ~$past(clr_mask)) == '0)); // R5

    AST_SAFE_HOLD: assert property (@(posedge clk) disable iff (rst)
        safe_mode_req |=> safe_mode_req); // R8

    AST_SAFE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(safe_mode_req) |-> $past(term_failed[WATCH_A] && term_failed[WATCH_B])); // R8
endmodule

bind bus_chg_monitor bus_chg_monitor_chk #(
    .NUM_TERM(NUM_TERM), .WATCH_A(WATCH_A), .WATCH_B(WATCH_B), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_addr(res_addr),
    .res_pass(res_pass), .clr_valid(clr_valid), .clr_addr(clr_addr),
    .bus_sel(bus_sel), .term_failed(term_failed), .safe_mode_req(safe_mode_req)
);

// File: tb/bus_chg_monitor_tb.sv
`timescale 1ns/1ps
module bus_chg_monitor_tb;
    localparam int NT = 32;
    localparam int WA = 1;
    localparam int WB = 2;
    localparam logic [31:0] INIT_B = 32'h0000_00F0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic res_valid = 1'b0;
    logic [4:0] res_addr = '0;
    logic res_pass = 1'b0;
    logic clr_valid = 1'b0;
    logic [4:0] clr_addr = '0;
    logic [4:0] diag_addr = '0;
    logic [31:0] bus_sel;
    logic [31:0] term_failed;
    logic safe_mode_req;
    logic [7:0] diag_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_tag = "R1";

    int m_stage [NT];
    int m_run   [NT];
    int m_bus   [NT];
    int m_err   [NT];
    int m_safe;

    always #4 clk = ~clk;

    bus_chg_monitor u_dut (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_addr(res_addr),
        .res_pass(res_pass), .clr_valid(clr_valid), .clr_addr(clr_addr),
        .diag_addr(diag_addr), .bus_sel(bus_sel), .term_failed(term_failed),
        .safe_mode_req(safe_mode_req), .diag_err(diag_err)
    );

    // Behavioural reference: stage 0 = home bus, 1 = moved, 2 = down
    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) begin
                m_stage[t] = 0; m_run[t] = 0; m_bus[t] = INIT_B[t]; m_err[t] = 0;
            end
            m_safe = 0;
        end else begin
            if (m_stage[WA] == 2 && m_stage[WB] == 2) m_safe = 1;
            for (int t = 0; t < NT; t++) begin
                if (clr_valid && clr_addr == t) begin
                    m_stage[t] = 0; m_run[t] = 0; m_bus[t] = INIT_B[t];
                end else if (res_valid && res_addr == t && m_stage[t] != 2) begin
                    if (res_pass) m_run[t] = 0;
                    else begin
                        if (m_err[t] < 255) m_err[t]++;
                        m_run[t]++;
                        if (m_run[t] == 3) begin
                            m_run[t] = 0;
                            if (m_stage[t] == 0) begin m_stage[t] = 1; m_bus[t] = 1 - m_bus[t]; end
                            else m_stage[t] = 2;
                        end
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] eb, ef;
        for (int t = 0; t < NT; t++) begin
            eb[t] = (m_bus[t] != 0);
            ef[t] = (m_stage[t] == 2);
        end
        check(bus_sel == eb, cur_tag, "bus_sel", bus_sel, eb);
        check(term_failed == ef, cur_tag, "term_failed", term_failed, ef);
        check(safe_mode_req == (m_safe != 0), cur_tag, "safe_mode_req", safe_mode_req, m_safe);
        check(diag_err == m_err[diag_addr], cur_tag, "diag_err", diag_err, m_err[diag_addr]);
    endtask

    task automatic step(bit rv, int a, bit p, bit cv, int ca);
        res_valid = rv; res_addr = 5'(a); res_pass = p;
        clr_valid = cv; clr_addr = 5'(ca);
        @(posedge clk); #2;
        res_valid = 0; clr_valid = 0;
        compare_all();
    endtask

    task automatic fail_n(int a, int n);
        for (int i = 0; i < n; i++) step(1, a, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 0;
        cur_tag = "R1";
        compare_all();
        check(bus_sel == 32'h0000_00F0, "R1", "initial bus_sel", bus_sel, 32'h0000_00F0);
        check(term_failed == 0 && !safe_mode_req, "R1", "no fault at reset", term_failed, 0);

        cur_tag = "R2"; diag_addr = 10;
        fail_n(10, 2); step(1, 10, 1, 0, 0); fail_n(10, 2);
        check(bus_sel[10] == 0, "R2", "pass restarts run", bus_sel[10], 0);

        cur_tag = "R3";
        fail_n(10, 1);
        check(bus_sel[10] == 1, "R3", "swap on third fail", bus_sel[10], 1);

        cur_tag = "R4";
        fail_n(10, 2);
        check(term_failed[10] == 0, "R4", "not down after two", term_failed[10], 0);
        fail_n(10, 1);
        check(term_failed[10] == 1, "R4", "down after three more", term_failed[10], 1);
        check(bus_sel[10] == 1, "R4", "stays on alternate", bus_sel[10], 1);

        cur_tag = "R5";
        fail_n(10, 3); step(1, 10, 1, 0, 0);
        check(diag_err == 8'd8, "R5", "err frozen while down", diag_err, 8);
        check(bus_sel[10] == 1 && term_failed[10] == 1, "R5", "state frozen", {bus_sel[10], term_failed[10]}, 3);

        cur_tag = "R6";
        step(0, 0, 0, 1, 10);
        check(bus_sel[10] == 0 && term_failed[10] == 0, "R6", "clear restores", {bus_sel[10], term_failed[10]}, 0);
        check(diag_err == 8'd8, "R6", "err kept by clear", diag_err, 8);

        cur_tag = "R10"; diag_addr = 11;
        fail_n(11, 2); step(1, 11, 0, 1, 11); fail_n(11, 2);
        check(bus_sel[11] == 0, "R10", "clear beats result", bus_sel[11], 0);
        check(diag_err == 8'd4, "R10", "result dropped", diag_err, 4);

        cur_tag = "R9"; diag_addr = 5;
        fail_n(5, 3);
        check(bus_sel == 32'h0000_00D0, "R9", "only terminal 5 moved", bus_sel, 32'h0000_00D0);

        cur_tag = "R7"; diag_addr = 20;
        for (int k = 0; k < 130; k++) begin fail_n(20, 2); step(1, 20, 1, 0, 0); end
        check(diag_err == 8'd255, "R7", "saturated count", diag_err, 255);
        check(bus_sel[20] == 0, "R7", "no swap with passes", bus_sel[20], 0);

        cur_tag = "R8"; diag_addr = 1;
        fail_n(1, 6);
        check(term_failed[1] == 1 && !safe_mode_req, "R8", "one watched down", safe_mode_req, 0);
        fail_n(2, 6);
        check(safe_mode_req == 0, "R8", "same cycle as second down", safe_mode_req, 0);
        step(0, 0, 0, 0, 0);
        check(safe_mode_req == 1, "R8", "safe one cycle later", safe_mode_req, 1);
        step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 2);
        check(safe_mode_req == 1, "R8", "safe sticky", safe_mode_req, 1);

        cur_tag = "R1";
        rst = 1; @(posedge clk); #2; rst = 0;
        compare_all();
        check(safe_mode_req == 0 && diag_err == 0, "R1", "reset clears all", safe_mode_req, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule